// File: doc/BRIEF.md
# Converter serial result port

This block is the device-side output logic of a converter's serial readout. A host pulls chip-select low to start a conversion cycle. The block then takes control of a tri-stateable data line and drives it low to report that a conversion is in progress. When the conversion engine presents a result through a one-cycle valid strobe, the block latches the 15-bit word. It then drives the line high as a leading ready marker.

The host then issues 16 serial clock pulses. On each falling serial clock edge the block moves the next result bit onto the line, most significant bit first. A receiver that samples on rising edges therefore sees a constant 1 and then the 15 result bits.

Chip-select and the serial clock are asynchronous to the system clock. Each passes through a two-stage synchronizer and an edge register before the control logic sees it. When chip-select rises after a complete transfer, the line goes back to high impedance. When it rises early, the cycle is abandoned and the line is released after a fixed three-cycle wind-down.

Top module: `adc_serial_port`

## Requirements
- R1: While rst_ni is low, sdat_oe_o is 0 at once, without waiting for a clock edge, and the block returns to idle.
- R2: Three system-clock cycles after cs_n_i falls, sdat_oe_o is 1 and sdat_o is 0 (busy). The line stays low until a result is accepted.
- R3: A res_valid_i pulse while busy latches res_data_i, and sdat_o goes to 1 (ready marker) on the next clock edge.
- R4: After the marker, each falling sclk_i edge puts the next result bit on sdat_o, bit 14 first. On the 16 rising edges a receiver reads 1, then bits 14 down to 0.
- R5: sclk_i pulses that occur before the ready marker do not advance the bit counter. A full 16-pulse readout that follows them still returns the complete word.
- R6: After the 16th falling edge, sdat_o holds bit 0. A chip-select rise then clears sdat_oe_o exactly 3 system-clock cycles after cs_n_i rises.
- R7: A chip-select rise before 16 falling edges aborts the cycle, whether busy or shifting. sdat_oe_o stays 1 until it clears exactly 6 system-clock cycles after cs_n_i rises.
- R8: A res_valid_i pulse while chip-select is high is ignored. After the next chip-select fall, the line stays low (busy) until a new strobe arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System (modulator) clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_n_i | input | 1 | Chip-select from host, active low, asynchronous |
| sclk_i | input | 1 | Serial clock from host, asynchronous |
| res_valid_i | input | 1 | One-cycle strobe: conversion result available |
| res_data_i | input | 15 | Conversion result word |
| sdat_o | output | 1 | Serial data / busy-ready value |
| sdat_oe_o | output | 1 | Output enable for the data line; 0 means high impedance |

## Verification
Serial clock pulses are sent before the result arrives. A design that counted them would skip the leading result bits, and the scoreboard would report a misaligned word. A result strobe is sent while chip-select is high. A design that latched it would raise the ready marker with no new strobe, so the busy line would not stay low. The bench measures release latency in system clocks for both a completed and an abandoned cycle. A design that skipped the abort wind-down, or released the line on the wrong path, would miss the 3- and 6-cycle marks. An asynchronous reset is applied mid-transfer to catch a reset that waits for a clock edge.

// File: rtl/adc_port_pkg.sv
package adc_port_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BUSY,
    ST_SHIFT,
    ST_DONE,
    ST_ABORT
  } port_state_e;
endpackage

// File: rtl/adc_sync.sv
module adc_sync #(
  parameter int  N       = 1,
  parameter int  STAGES  = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= RST_VAL;
    else         stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= RST_VAL;
      else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/adc_edge_det.sv
module adc_edge_det #(
  parameter int N = 1,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] sig_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= sig_i;
  end

  assign rise_o = sig_i & ~prev_q;
  assign fall_o = ~sig_i & prev_q;
endmodule

// File: rtl/adc_result_shifter.sv
module adc_result_shifter
  import adc_port_pkg::*;
#(
  parameter int W         = 15,
  parameter int ABORT_CYC = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cs_fall_i,
  input  logic         cs_rise_i,
  input  logic         sclk_fall_i,
  input  logic         sclk_rise_i,
  input  logic         res_valid_i,
  input  logic [W-1:0] res_data_i,
  output logic         sdat_o,
  output logic         oe_o
);
  localparam int PULSES = W + 1;
  localparam int CW     = $clog2(PULSES + 1);
  localparam int AW     = $clog2(ABORT_CYC + 1);

  port_state_e  state_q;
  logic [W-1:0] shreg_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] abort_q;
  logic          sdat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      shreg_q <= '0;
      cnt_q   <= '0;
      abort_q <= '0;
      sdat_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          sdat_q <= 1'b0;
          if (cs_fall_i) begin
            state_q <= ST_BUSY;
            cnt_q   <= '0;
          end
        end
        ST_BUSY: begin
          if (cs_rise_i) begin
            state_q <= ST_ABORT;
            abort_q <= '0;
          end else if (res_valid_i) begin
            shreg_q <= res_data_i;
            sdat_q  <= 1'b1;
            cnt_q   <= '0;
            state_q <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (cs_rise_i) begin
            state_q <= ST_ABORT;
            abort_q <= '0;
          end else if (sclk_fall_i) begin
            if (cnt_q < CW'(W)) begin
              sdat_q  <= shreg_q[W-1];
              shreg_q <= shreg_q << 1;
            end
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CW'(PULSES - 1)) state_q <= ST_DONE;
          end
        end
        ST_DONE: begin
          if (cs_rise_i) state_q <= ST_IDLE;
        end
        ST_ABORT: begin
          abort_q <= abort_q + 1'b1;
          if (abort_q == AW'(ABORT_CYC - 1)) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sdat_o = sdat_q;
  assign oe_o   = (state_q != ST_IDLE);

  AST_BUSY_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BUSY) |-> !sdat_q); // R2
  AST_READY_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BUSY && res_valid_i && !cs_rise_i) |=> sdat_q); // R3
  AST_SHIFT_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SHIFT && sclk_rise_i) |=> $stable(sdat_q)); // R4
  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(PULSES)); // R4
  AST_NO_EARLY_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BUSY && sclk_fall_i && !res_valid_i) |=> cnt_q == '0); // R5
  AST_ABORT_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ABORT) |-> (abort_q < AW'(ABORT_CYC) && oe_o)); // R7
  AST_IDLE_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |=> (state_q != ST_SHIFT)); // R8
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port #(
  parameter int W         = 15,
  parameter int SYNC_STG  = 2,
  parameter int ABORT_CYC = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cs_n_i,
  input  logic         sclk_i,
  input  logic         res_valid_i,
  input  logic [W-1:0] res_data_i,
  output logic         sdat_o,
  output logic         sdat_oe_o
);
  localparam logic [1:0] PIN_IDLE = 2'b10; // {cs_n, sclk}

  logic [1:0] pins_s, rise_w, fall_w;

  adc_sync #(.N(2), .STAGES(SYNC_STG), .RST_VAL(PIN_IDLE)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({cs_n_i, sclk_i}),
    .q_o    (pins_s)
  );

  adc_edge_det #(.N(2), .RST_VAL(PIN_IDLE)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (pins_s),
    .rise_o (rise_w),
    .fall_o (fall_w)
  );

  adc_result_shifter #(.W(W), .ABORT_CYC(ABORT_CYC)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_fall_i   (fall_w[1]),
    .cs_rise_i   (rise_w[1]),
    .sclk_fall_i (fall_w[0]),
    .sclk_rise_i (rise_w[0]),
    .res_valid_i (res_valid_i),
    .res_data_i  (res_data_i),
    .sdat_o      (sdat_o),
    .oe_o        (sdat_oe_o)
  );

  AST_RESET_IDLE: assert property (@(posedge clk_i)
    !rst_ni |-> !sdat_oe_o); // R1
endmodule

// File: tb/adc_serial_port_tb.sv
`timescale 1ns/1ps
module adc_serial_port_tb_top;
  localparam int W = 15;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         cs_n = 1'b1;
  logic         sclk = 1'b0;
  logic         res_valid = 1'b0;
  logic [W-1:0] res_data = '0;
  logic         sdat, sdat_oe;

  int  n_run = 0;
  int  n_fail = 0;
  bit  mon_en = 1'b0;
  bit  finished = 1'b0;
  logic exp_q[$];

  always #4 clk = ~clk;

  adc_serial_port dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .cs_n_i      (cs_n),
    .sclk_i      (sclk),
    .res_valid_i (res_valid),
    .res_data_i  (res_data),
    .sdat_o      (sdat),
    .sdat_oe_o   (sdat_oe)
  );

  task automatic check(string req, logic act, logic exp, string what);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic check_int(string req, int act, int exp, string what);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // driver side of the scoreboard
  task automatic push_word(logic [W-1:0] w);
    exp_q.push_back(1'b1);
    for (int i = W - 1; i >= 0; i--) exp_q.push_back(w[i]);
  endtask

  // monitor: receiver samples on rising sclk
  always @(posedge sclk) begin
    if (mon_en) begin
      n_run++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R4 unexpected bit: got %0b expected none", sdat);
      end else begin
        logic e;
        e = exp_q.pop_front();
        if (sdat !== e || sdat_oe !== 1'b1) begin
          n_fail++;
          $display("FAIL R4 serial bit: got %0b (oe %0b) expected %0b", sdat, sdat_oe, e);
        end
      end
    end
  end

  task automatic pulses(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) sclk = 1'b1;
      repeat (8) @(negedge clk);
      sclk = 1'b0;
      repeat (8) @(negedge clk);
    end
  endtask

  task automatic strobe(logic [W-1:0] w);
    @(negedge clk);
    res_valid = 1'b1;
    res_data  = w;
    @(negedge clk);
    res_valid = 1'b0;
    res_data  = '0;
  endtask

  task automatic cs_low();
    @(negedge clk) cs_n = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // cycles from cs rise to oe low
  task automatic cs_release(output int n);
    @(negedge clk) cs_n = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (sdat_oe && n < 30);
  endtask

  task automatic full_transfer(logic [W-1:0] w, int early);
    int lat;
    cs_low();
    check("R2", sdat_oe, 1'b1, "oe after cs fall");
    check("R2", sdat, 1'b0, "busy level");
    if (early > 0) pulses(early); // R5: ignored pulses
    check("R5", sdat, 1'b0, "still busy after early pulses");
    strobe(w);
    check("R3", sdat, 1'b1, "ready marker");
    push_word(w);
    mon_en = 1'b1;
    pulses(W + 1);
    mon_en = 1'b0;
    check_int("R4", exp_q.size(), 0, "bits left in scoreboard");
    exp_q.delete();
    check("R6", sdat, w[0], "bit 0 held after 16 pulses");
    cs_release(lat);
    check_int("R6", lat, 3, "release latency after full transfer");
  endtask

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    check("R1", sdat_oe, 1'b0, "oe in reset");
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", sdat_oe, 1'b0, "oe idle after reset");

    full_transfer(15'h5A3C, 0);
    full_transfer(15'h7FFF, 2);   // R5
    full_transfer(15'h0001, 3);   // R5

    // R8: strobe while cs high is ignored
    strobe(15'h1234);
    check("R8", sdat_oe, 1'b0, "oe stays low on idle strobe");
    cs_low();
    repeat (10) @(negedge clk);
    check("R8", sdat, 1'b0, "no stale ready marker");
    strobe(15'h2AAA);
    check("R8", sdat, 1'b1, "marker on fresh strobe");
    push_word(15'h2AAA);
    mon_en = 1'b1;
    pulses(W + 1);
    mon_en = 1'b0;
    exp_q.delete();
    cs_release(lat);
    check_int("R6", lat, 3, "release latency second path");

    // R7: abort while shifting
    cs_low();
    strobe(15'h4321);
    pulses(5);
    @(negedge clk) cs_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R7", sdat_oe, 1'b1, "oe held during wind-down");
    @(negedge clk);
    check("R7", sdat_oe, 1'b0, "oe low 6 cycles after abort");

    // R7: abort while busy
    cs_low();
    cs_release(lat);
    check_int("R7", lat, 6, "abort latency from busy");

    // R1: asynchronous reset mid-transfer
    cs_low();
    strobe(15'h0F0F);
    pulses(2);
    @(negedge clk);
    #1 rst_ni = 1'b0;
    #1 check("R1", sdat_oe, 1'b0, "async reset clears oe");
    cs_n = 1'b1;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", sdat_oe, 1'b0, "idle after reset release");

    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule